// File: doc/BRIEF.md
# Button Gesture Classifier

The classifier watches one push-button and turns a single gesture into a result code: nothing pressed, a single click, a double click, or a long hold. A one-cycle start strobe arms it. It first passes the raw button level through a register synchronizer. It then times the gesture against a free-running tick counter, which a power-of-two prescaler drives from the system clock.

When the button is down at start, a hold deadline is set from a programmable time in milliseconds. Releasing the button before that deadline replaces it with a fixed double-click window that starts at the moment of release. A second press inside the window reports a double click. If the window runs out, the result is a single click. Both deadlines wrap modulo the counter width, and the block tests for them by exact equality with the tick count.

The default parameters give a 48 MHz clock divided by 1024, a 16-bit counter, a 500 ms window and 1000 ms as the hold time used when the request is zero.

Top module: `gesture_classifier`

## Requirements
- R1: The tick counter advances once every 2^PRESC_BITS clocks and wraps from 2^CNT_W-1 to 0. Deadlines are computed and compared modulo 2^CNT_W, so a deadline that lies past the wrap is still met.
- R2: A hold request of M milliseconds sets a deadline of (CLK_KHZ × M) >> PRESC_BITS ticks after the tick value at the start edge.
- R3: If the synchronized button is released when start is sampled, done pulses on that same edge and the result is 0 (no click).
- R4: While the button stays down, the result 3 (hold) is reported on the edge after the tick count equals the hold deadline.
- R5: A hold request of 0 ms is treated as DEF_MS (1000 ms by default).
- R6: The first release re-captures the start point and replaces the deadline with WIN_MS worth of ticks (500 ms by default).
- R7: A press seen after the release and before the window expires gives result 2 (double click) on the edge after that press is seen.
- R8: If the window expires with no second press, the result is 1 (single click).
- R9: The codes are 0 = none, 1 = single, 2 = double, 3 = hold. Done is high for exactly one cycle per gesture. The result holds its value until the next gesture completes.
- R10: A start strobe that arrives while a classification is in progress has no effect on its timing or result.
- R11: The button is sampled through two register stages. A press applied in the same cycle as start is not yet seen, and the block decides on a press two edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| btn_raw | input | 1 | Raw button level, 1 = pressed |
| start | input | 1 | One-cycle strobe that arms a classification |
| hold_ms | input | MS_W | Hold time in milliseconds, 0 selects the default |
| done | output | 1 | One-cycle pulse when a result is ready |
| result | output | 3 | Gesture code (0 none, 1 single, 2 double, 3 hold) |

## Verification
The hardest case to reach is a deadline that lands beyond the wrap of the free-running tick counter. The counter cannot be preset from the ports, so only the passage of time brings it near its top value. The bench scales the prescaler and clock rate down so that a tick is two clocks and one millisecond. It lets the counter run until it is a few dozen ticks short of 65536, then starts a hold whose deadline lies past zero. A cycle-exact behavioural model runs beside the design and confirms that the hold is still reported on the correct edge.

// File: rtl/gc_pkg.sv
`timescale 1ns/1ps
package gc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HELD = 2'd1,
    PH_GAP  = 2'd2
  } phase_t;

  localparam logic [2:0] RES_NONE   = 3'd0;
  localparam logic [2:0] RES_SINGLE = 3'd1;
  localparam logic [2:0] RES_DOUBLE = 3'd2;
  localparam logic [2:0] RES_HOLD   = 3'd3;

  // zero request falls back to the default duration
  function automatic logic [31:0] eff_ms(input logic [31:0] ms, input logic [31:0] dflt);
    return (ms == 32'd0) ? dflt : ms;
  endfunction

  // milliseconds to ticks: clock kHz times ms, divided by the prescale ratio
  function automatic logic [31:0] ms_to_ticks(input logic [31:0] ms,
                                              input logic [31:0] khz,
                                              input int unsigned sh);
    logic [63:0] prod;
    prod = {32'd0, khz} * {32'd0, ms};
    prod = prod >> sh;
    return prod[31:0];
  endfunction

endpackage

// File: rtl/gc_sync.sv
`timescale 1ns/1ps
module gc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/gc_tick_timer.sv
`timescale 1ns/1ps
module gc_tick_timer #(
  parameter int PRESC_BITS = 10,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick_stb,
  output logic [CNT_W-1:0] tick_cnt
);
  localparam logic [PRESC_BITS-1:0] PRE_ONE = PRESC_BITS'(1);
  localparam logic [CNT_W-1:0]      CNT_ONE = CNT_W'(1);

  logic [PRESC_BITS-1:0] pre;

  assign tick_stb = &pre;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pre      <= '0;
      tick_cnt <= '0;
    end else begin
      pre <= pre + PRE_ONE;
      if (tick_stb) tick_cnt <= tick_cnt + CNT_ONE;
    end
  end
endmodule

// File: rtl/gc_deadline.sv
`timescale 1ns/1ps
module gc_deadline
  import gc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MS_W       = 16,
  parameter int CLK_KHZ    = 48000,
  parameter int PRESC_BITS = 10,
  parameter int WIN_MS     = 500,
  parameter int DEF_MS     = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tick_cnt,
  input  logic [MS_W-1:0]  hold_ms,
  input  logic             arm_hold,
  input  logic             arm_win,
  output logic             deadline_hit
);
  localparam logic [CNT_W-1:0] WIN_TICKS =
    CNT_W'(ms_to_ticks(32'(WIN_MS), 32'(CLK_KHZ), PRESC_BITS));

  logic [CNT_W-1:0] hold_ticks;
  logic [CNT_W-1:0] target;

  assign hold_ticks = CNT_W'(ms_to_ticks(eff_ms(32'(hold_ms), 32'(DEF_MS)),
                                         32'(CLK_KHZ), PRESC_BITS));

  // sums wrap modulo 2^CNT_W on purpose
  always_ff @(posedge clk or posedge rst) begin
    if (rst)           target <= '0;
    else if (arm_hold) target <= tick_cnt + hold_ticks;
    else if (arm_win)  target <= tick_cnt + WIN_TICKS;
  end

  assign deadline_hit = (tick_cnt == target);
endmodule

// File: rtl/gc_fsm.sv
`timescale 1ns/1ps
module gc_fsm
  import gc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       btn_s,
  input  logic       deadline_hit,
  output logic       arm_hold,
  output logic       arm_win,
  output phase_t     phase,
  output logic       done,
  output logic [2:0] result
);
  phase_t     ph_nx;
  logic       fin;
  logic [2:0] res_nx;

  always_comb begin
    ph_nx    = phase;
    arm_hold = 1'b0;
    arm_win  = 1'b0;
    fin      = 1'b0;
    res_nx   = RES_NONE;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          if (btn_s) begin
            arm_hold = 1'b1;
            ph_nx    = PH_HELD;
          end else begin
            fin    = 1'b1;
            res_nx = RES_NONE;
          end
        end
      end
      PH_HELD: begin
        if (!btn_s) begin
          arm_win = 1'b1;
          ph_nx   = PH_GAP;
        end else if (deadline_hit) begin
          fin    = 1'b1;
          res_nx = RES_HOLD;
          ph_nx  = PH_IDLE;
        end
      end
      PH_GAP: begin
        if (btn_s) begin
          fin    = 1'b1;
          res_nx = RES_DOUBLE;
          ph_nx  = PH_IDLE;
        end else if (deadline_hit) begin
          fin    = 1'b1;
          res_nx = RES_SINGLE;
          ph_nx  = PH_IDLE;
        end
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase  <= PH_IDLE;
      done   <= 1'b0;
      result <= RES_NONE;
    end else begin
      phase <= ph_nx;
      done  <= fin;
      if (fin) result <= res_nx;
    end
  end
endmodule

// File: rtl/gesture_classifier.sv
`timescale 1ns/1ps
module gesture_classifier
  import gc_pkg::*;
#(
  parameter int CLK_KHZ     = 48000,
  parameter int PRESC_BITS  = 10,
  parameter int CNT_W       = 16,
  parameter int MS_W        = 16,
  parameter int WIN_MS      = 500,
  parameter int DEF_MS      = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            btn_raw,
  input  logic            start,
  input  logic [MS_W-1:0] hold_ms,
  output logic            done,
  output logic [2:0]      result
);
  logic             btn_s;
  logic             tick_stb;
  logic [CNT_W-1:0] tick_cnt;
  logic             deadline_hit;
  logic             arm_hold;
  logic             arm_win;
  phase_t           phase;

  // named events for the checker
  logic busy, in_held, in_gap;
  assign busy    = (phase != PH_IDLE);
  assign in_held = (phase == PH_HELD);
  assign in_gap  = (phase == PH_GAP);

  gc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(btn_raw), .q(btn_s)
  );

  gc_tick_timer #(.PRESC_BITS(PRESC_BITS), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .tick_stb(tick_stb), .tick_cnt(tick_cnt)
  );

  gc_deadline #(
    .CNT_W(CNT_W), .MS_W(MS_W), .CLK_KHZ(CLK_KHZ),
    .PRESC_BITS(PRESC_BITS), .WIN_MS(WIN_MS), .DEF_MS(DEF_MS)
  ) dl_i (
    .clk(clk), .rst(rst), .tick_cnt(tick_cnt), .hold_ms(hold_ms),
    .arm_hold(arm_hold), .arm_win(arm_win), .deadline_hit(deadline_hit)
  );

  gc_fsm fsm_i (
    .clk(clk), .rst(rst), .start(start), .btn_s(btn_s),
    .deadline_hit(deadline_hit), .arm_hold(arm_hold), .arm_win(arm_win),
    .phase(phase), .done(done), .result(result)
  );
endmodule

// File: rtl/gc_checker.sv
`timescale 1ns/1ps
module gc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             btn_s,
  input logic             busy,
  input logic             in_held,
  input logic             in_gap,
  input logic             deadline_hit,
  input logic             tick_stb,
  input logic [CNT_W-1:0] tick_cnt,
  input logic             done,
  input logic [2:0]       result
);
  // R1
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_stb |=> tick_cnt == $past(tick_cnt) + CNT_W'(1));
  // R1
  tick_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_stb |=> $stable(tick_cnt));
  // R3
  no_click_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !btn_s) |=> (done && result == 3'd0));
  // R4
  hold_res_chk: assert property (@(posedge clk) disable iff (rst)
    (in_held && btn_s && deadline_hit) |=> (done && result == 3'd3));
  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (in_held && !btn_s) |=> (in_gap && !done));
  // R7
  dbl_res_chk: assert property (@(posedge clk) disable iff (rst)
    (in_gap && btn_s) |=> (done && result == 3'd2));
  // R8
  single_res_chk: assert property (@(posedge clk) disable iff (rst)
    (in_gap && !btn_s && deadline_hit) |=> (done && result == 3'd1));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !done);
endmodule

bind gesture_classifier gc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .btn_s(btn_s), .busy(busy),
  .in_held(in_held), .in_gap(in_gap), .deadline_hit(deadline_hit),
  .tick_stb(tick_stb), .tick_cnt(tick_cnt), .done(done), .result(result)
);

// File: tb/gesture_classifier_tb_top.sv
`timescale 1ns/1ps
module gesture_classifier_tb_top;
  localparam int KHZ   = 2;
  localparam int PB    = 1;
  localparam int PDIV  = 2;
  localparam int WRAP  = 65536;
  localparam int WIN   = 500;
  localparam int DEFMS = 1000;
  localparam int WDOG  = 180000;

  logic        clk = 1'b0;
  logic        rst;
  logic        btn;
  logic        start;
  logic [15:0] hold_ms;
  logic        done;
  logic [2:0]  result;

  always #2.5 clk = ~clk;

  gesture_classifier #(
    .CLK_KHZ(KHZ), .PRESC_BITS(PB), .CNT_W(16), .MS_W(16),
    .WIN_MS(WIN), .DEF_MS(DEFMS), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .btn_raw(btn), .start(start),
    .hold_ms(hold_ms), .done(done), .result(result)
  );

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  bit ended  = 0;

  // ---------------- behavioural reference ----------------
  int m_pre, m_tick, m_ph, m_tgt, m_q0, m_q1, m_done, m_code, m_seen;

  function automatic int ticks_of(int ms, int dflt);
    int e;
    e = (ms == 0) ? dflt : ms;
    return ((e * KHZ) / (2 ** PB)) % WRAP;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_tick = 0; m_ph = 0; m_tgt = 0;
      m_q0 = 0; m_q1 = 0; m_done = 0; m_code = 0;
    end else begin
      m_seen = m_q1;
      m_done = 0;
      if (m_ph == 0) begin
        if (start) begin
          if (m_seen == 0) begin m_done = 1; m_code = 0; end
          else begin m_tgt = (m_tick + ticks_of(int'(hold_ms), DEFMS)) % WRAP; m_ph = 1; end
        end
      end else if (m_ph == 1) begin
        if (m_seen == 0) begin m_tgt = (m_tick + ticks_of(WIN, WIN)) % WRAP; m_ph = 2; end
        else if (m_tick == m_tgt) begin m_done = 1; m_code = 3; m_ph = 0; end
      end else begin
        if (m_seen != 0) begin m_done = 1; m_code = 2; m_ph = 0; end
        else if (m_tick == m_tgt) begin m_done = 1; m_code = 1; m_ph = 0; end
      end
      if (m_pre == PDIV - 1) begin m_pre = 0; m_tick = (m_tick + 1) % WRAP; end
      else m_pre = m_pre + 1;
      m_q1 = m_q0;
      m_q0 = int'(btn);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // per-cycle comparison against the reference, R9 protocol
  always @(negedge clk) begin
    ncyc++;
    if (!rst) begin
      check(done == m_done[0], "R9", "done vs model", int'(done), m_done);
      check(int'(result) == m_code, "R9", "result vs model", int'(result), m_code);
    end
    if (ncyc > WDOG && !ended) begin
      check(1'b0, "R9", "watchdog expired, gesture never completed", ncyc, WDOG);
      finish_run();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start(input int ms);
    @(negedge clk);
    start   = 1'b1;
    hold_ms = 16'(ms);
    @(negedge clk);
    start   = 1'b0;
  endtask

  // counts negedges from now until done is seen (0 if already high)
  task automatic wait_done(output int c);
    c = 0;
    while (!done && c < 5000) begin
      @(negedge clk);
      c++;
    end
  endtask

  int c, t0;

  initial begin
    rst = 1'b1; btn = 1'b0; start = 1'b0; hold_ms = 16'd0;
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R9", "reset done", int'(done), 0);
    check(result == 3'd0, "R9", "reset result", int'(result), 0);

    // R3: released button at start
    do_start(100);
    wait_done(c);
    check(c == 0, "R3", "no-click latency", c, 0);
    check(result == 3'd0, "R3", "no-click code", int'(result), 0);
    idle(10);

    // R11: press in the same cycle as start is not yet seen
    @(negedge clk);
    btn = 1'b1; start = 1'b1; hold_ms = 16'd100;
    @(negedge clk);
    start = 1'b0;
    wait_done(c);
    check(c == 0, "R11", "same-cycle press latency", c, 0);
    check(result == 3'd0, "R11", "same-cycle press code", int'(result), 0);
    btn = 1'b0;
    idle(10);

    // R4: hold of 100 ms
    btn = 1'b1; idle(5);
    do_start(100);
    wait_done(c);
    check(result == 3'd3, "R4", "hold code", int'(result), 3);
    check(c >= 196 && c <= 202, "R4", "hold latency", c, 199);
    btn = 1'b0;
    idle(40);
    // R9: code stays put while idle
    check(result == 3'd3, "R9", "code held after done", int'(result), 3);
    check(done == 1'b0, "R9", "done low while idle", int'(done), 0);

    // R2: deadline formula at 300 ms
    btn = 1'b1; idle(5);
    do_start(300);
    wait_done(c);
    check(result == 3'd3, "R2", "hold code 300ms", int'(result), 3);
    check(c >= 596 && c <= 602, "R2", "hold latency 300ms", c, 599);
    btn = 1'b0; idle(10);

    // R5: zero request means default
    btn = 1'b1; idle(5);
    do_start(0);
    wait_done(c);
    check(result == 3'd3, "R5", "default hold code", int'(result), 3);
    check(c >= 1996 && c <= 2002, "R5", "default hold latency", c, 1999);
    btn = 1'b0; idle(10);

    // R6 + R8: single click, window measured from release
    btn = 1'b1; idle(5);
    do_start(100);
    idle(40);
    btn = 1'b0;
    wait_done(c);
    check(result == 3'd1, "R8", "single code", int'(result), 1);
    check(c >= 1000 && c <= 1006, "R6", "window from release", c, 1003);
    idle(10);

    // R7: double click
    btn = 1'b1; idle(5);
    do_start(100);
    idle(40);
    btn = 1'b0;
    idle(100);
    btn = 1'b1;
    wait_done(c);
    check(result == 3'd2, "R7", "double code", int'(result), 2);
    check(c == 3, "R7", "double latency", c, 3);
    btn = 1'b0; idle(10);

    // R10: second start during a hold is ignored
    btn = 1'b1; idle(5);
    do_start(100);
    t0 = ncyc;
    idle(50);
    do_start(0);
    wait_done(c);
    check(result == 3'd3, "R10", "code after ignored start", int'(result), 3);
    check((ncyc - t0) >= 196 && (ncyc - t0) <= 202, "R10", "timing unchanged",
          ncyc - t0, 199);
    btn = 1'b0; idle(20);

    // R1: hold whose deadline lies past the counter wrap
    while (!(m_tick == 65500 && m_pre == 0)) @(negedge clk);
    btn = 1'b1; idle(5);
    do_start(100);
    wait_done(c);
    check(result == 3'd3, "R1", "hold across wrap code", int'(result), 3);
    check(c >= 196 && c <= 202, "R1", "hold across wrap latency", c, 199);
    check(m_tick < 200, "R1", "counter wrapped", m_tick, 64);
    btn = 1'b0; idle(10);

    finish_run();
  end
endmodule